// File: doc/BRIEF.md
# Write Completion Status Readback

This block sits on the read path of a nonvolatile memory and forms the byte returned to the host. While the program sequencer reports that an internal write is in progress, a read does not return array contents. It returns a status pattern instead, and the host polls that pattern to learn when programming has finished.

The status pattern offers two detection methods at once. The top data bit carries the inverse of the top bit of the most recently written byte, so it reads true only once the write is over. A second bit flips on every read access while the write runs. The remaining bits repeat the last written byte. When busy drops, the raw array data passes straight through on every bit.

The busy flag comes from outside the block. It covers any timed write, including a write attempted while protection is active, in which no data is committed. The block itself does not generate busy and does not model tri-state pins.

Top module: `write_done_status`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the stored last byte is 0 and the toggle bit is 0. A busy read before any write or read strobe therefore returns 8'h80.
- R2: While busy is 1, rd_data bit 7 (POLL_BIT) equals the inverse of bit 7 of the last written byte.
- R3: While busy is 1, rd_data bits 5:0 equal bits 5:0 of the last written byte.
- R4: While busy is 1, each 0-to-1 change of rd_stb, as sampled at a clock edge, flips rd_data bit 6 (TOG_BIT). The new value is visible from the clock edge after the edge at which the rise is seen.
- R5: A read strobe held high over several edges flips the toggle bit only once.
- R6: While busy is 0, rd_data equals arr_data on all bits in the same cycle.
- R7: While busy is 0, the toggle bit holds its value, and read strobe edges do not change it. This is seen on bit 6 when busy next rises.
- R8: The last byte register captures wr_data at every clock edge where wr_stb is 1; the last strobe wins. Without wr_stb the register holds its value.
- R9: The status pattern appears in the same cycle that busy rises, before any read strobe, so polling can start at any point in the write. This holds whether or not data is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Internal write in progress, from the program sequencer |
| wr_stb | input | 1 | Accepted write strobe; captures wr_data |
| wr_data | input | DATA_W | Byte of the accepted write |
| rd_stb | input | 1 | Read access strobe (level; rising edge counts as one read) |
| arr_data | input | DATA_W | Raw data read from the array |
| rd_data | output | DATA_W | Byte returned to the host |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, bit 7 as the inverted poll bit and bit 6 as the toggle bit. These are the positions the requirements name. With these values every field of the status pattern can be seen at the ports. The random phase mixes busy periods, write strobes and read strobes of varying length, which reaches both held strobes and rising edges of the strobe while the block is idle.

// File: rtl/wds_pkg.sv
// Shared types for the write completion status readback block.
package wds_pkg;
    // Source selected for the read data path.
    typedef enum logic {
        SRC_ARRAY  = 1'b0,
        SRC_STATUS = 1'b1
    } rd_src_e;
endpackage

// File: rtl/wds_last_byte.sv
// Holds the byte of the most recent accepted write.
// Assumes wr_stb is already qualified by the write controller.
module wds_last_byte #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] last_q
);
    // Capture the written byte on each accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= '0;
        else if (wr_stb) last_q <= wr_data;
    end

    // R8
    last_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> last_q == $past(wr_data));
    // R8
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(last_q));
endmodule

// File: rtl/wds_toggle.sv
// Toggle flip-flop for status polling: it flips once for each rising edge
// of the read strobe seen while busy, and holds while idle.
// Assumes rd_stb is synchronous to clk.
module wds_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_stb,
    output logic tog_q
);
    logic rd_q;
    logic rd_rise;

    // Keep last sampled strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_stb;
    end

    // Rising edge of the read strobe.
    always_comb rd_rise = rd_stb & ~rd_q;

    // Flip on a read edge during busy only.
    always_ff @(posedge clk) begin
        if (!rst_n)               tog_q <= 1'b0;
        else if (busy && rd_rise) tog_q <= ~tog_q;
    end

    // R4
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_stb && !rd_q) |=> tog_q != $past(tog_q));
    // R5
    tog_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_q) |=> $stable(tog_q));
    // R7
    tog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tog_q));
endmodule

// File: rtl/wds_status_mux.sv
// Builds the status pattern and picks it or the array data.
// Assumes POLL_BIT and TOG_BIT are distinct and below W.
module wds_status_mux
    import wds_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter int unsigned POLL_BIT = W - 1,
    parameter int unsigned TOG_BIT  = W - 2
) (
    input  logic         busy,
    input  logic [W-1:0] last_q,
    input  logic         tog_q,
    input  logic [W-1:0] arr_data,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] status;
    rd_src_e      src;

    // Per-bit status source: inverted poll bit, toggle bit, or last byte.
    for (genvar i = 0; i < W; i++) begin : g_stat
        if (i == POLL_BIT) begin : g_poll
            assign status[i] = ~last_q[i];
        end else if (i == TOG_BIT) begin : g_tog
            assign status[i] = tog_q;
        end else begin : g_copy
            assign status[i] = last_q[i];
        end
    end

    // Choose the source from the busy flag.
    always_comb src = busy ? SRC_STATUS : SRC_ARRAY;

    // Drive the read data.
    always_comb rd_data = (src == SRC_STATUS) ? status : arr_data;
endmodule

// File: rtl/write_done_status.sv
// Write completion status readback: while busy, reads return the poll
// and toggle status pattern. Otherwise, reads return array data.
// Assumes busy comes from the program sequencer (including
// protected-write timing) and that all inputs are synchronous to clk.
module write_done_status #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned POLL_BIT = DATA_W - 1,
    parameter int unsigned TOG_BIT  = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] last_q;
    logic              tog_q;

    wds_last_byte #(.W(DATA_W)) u_last (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
        .wr_data(wr_data), .last_q(last_q)
    );

    wds_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .rd_stb(rd_stb), .tog_q(tog_q)
    );

    wds_status_mux #(.W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_mux (
        .busy(busy), .last_q(last_q), .tog_q(tog_q),
        .arr_data(arr_data), .rd_data(rd_data)
    );

    // R2
    poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_data[POLL_BIT] != last_q[POLL_BIT]);
    // R6
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> rd_data == arr_data);
    // R4
    tog_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_data[TOG_BIT] == tog_q);
endmodule

// File: tb/sim_write_done_status.sv
module sim_write_done_status;
    logic       clk = 1'b0;
    logic       rst_n, busy, wr_stb, rd_stb;
    logic [7:0] wr_data, arr_data, rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0] m_last;
    logic       m_tog, m_rdq;

    always #2.5 clk = ~clk;

    write_done_status u0 (
        .clk(clk), .rst_n(rst_n), .busy(busy), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .arr_data(arr_data),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] expect_out(logic b, logic [7:0] arr);
        if (b) return {~m_last[7], m_tog, m_last[5:0]};
        return arr;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: model follows the inputs stable at the edge; return at negedge.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_last = 8'h00; m_tog = 1'b0; m_rdq = 1'b0;
        end else begin
            if (wr_stb) m_last = wr_data;
            if (busy && rd_stb && !m_rdq) m_tog = ~m_tog;
            m_rdq = rd_stb;
        end
        @(negedge clk);
        #0.5;
    endtask

    task automatic check_fields(string ctx);
        logic [7:0] e;
        e = expect_out(busy, arr_data);
        if (busy) begin
            chk({ctx, " R2 poll bit"}, {7'b0, rd_data[7]}, {7'b0, e[7]});
            chk({ctx, " R4 toggle bit"}, {7'b0, rd_data[6]}, {7'b0, e[6]});
            chk({ctx, " R3 low bits"}, {2'b0, rd_data[5:0]}, {2'b0, e[5:0]});
        end else begin
            chk({ctx, " R6 array pass"}, rd_data, e);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic t0;
        void'($urandom(32'd7341));
        rst_n = 1'b0; busy = 1'b1; wr_stb = 1'b0; rd_stb = 1'b0;
        wr_data = 8'hFF; arr_data = 8'h3C;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state seen through a busy read
        chk("R1 reset status", rd_data, 8'h80);

        // R8, R2, R3: write then read status
        busy = 1'b0; wr_stb = 1'b1; wr_data = 8'hA5; tick();
        wr_stb = 1'b0; busy = 1'b1; #0.5;
        chk("R9 status without read", rd_data, 8'h25);
        tick();
        chk("R2 R3 after write A5", rd_data, 8'h25);

        // R8: back-to-back writes, last wins
        wr_stb = 1'b1; wr_data = 8'h12; tick();
        wr_data = 8'hC3; tick();
        wr_stb = 1'b0; wr_data = 8'h00; tick();
        chk("R8 last write wins", rd_data, 8'h03);

        // R4, R5: read strobe edges and holds
        rd_stb = 1'b1; tick();
        chk("R4 first flip", rd_data, 8'h43);
        tick(); tick();
        chk("R5 held strobe", rd_data, 8'h43);
        rd_stb = 1'b0; tick();
        rd_stb = 1'b1; tick();
        chk("R4 second flip", rd_data, 8'h03);
        rd_stb = 1'b0; tick();
        rd_stb = 1'b1; tick();
        chk("R4 third flip", rd_data, 8'h43);
        rd_stb = 1'b0; tick();

        // R6: idle passes array data
        busy = 1'b0; arr_data = 8'h5A; tick();
        chk("R6 idle array", rd_data, 8'h5A);
        // R7: read edges while idle leave toggle alone
        t0 = m_tog;
        for (int k = 0; k < 3; k++) begin
            rd_stb = 1'b1; tick(); rd_stb = 1'b0; tick();
            chk("R6 idle read", rd_data, 8'h5A);
        end
        busy = 1'b1; #0.5;
        chk("R7 toggle held over idle", {7'b0, rd_data[6]}, {7'b0, t0});
        tick();

        // Random phase
        for (int n = 0; n < 2000; n++) begin
            if ($urandom_range(0, 9) == 0) busy = ~busy;
            wr_stb   = ($urandom_range(0, 3) == 0);
            wr_data  = 8'($urandom);
            rd_stb   = ($urandom_range(0, 2) != 0) ? rd_stb : ~rd_stb;
            arr_data = 8'($urandom);
            #0.5;
            check_fields("rand pre");
            tick();
            check_fields("rand post");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule